// File: doc/BRIEF.md
# Two-Level Branch Direction Predictor

This block predicts whether a fetched branch will be taken. It keeps a table of 2-bit entries and a short shift register of the outcomes of the most recently resolved branches. The prediction index is made by joining that outcome history with the word-address bits of the fetch PC. The history bits pick one of several entry sets, and the PC bits pick the entry inside the set. The prediction is combinational, so it is ready in the same cycle as the fetch PC. The index used is also output so that fetch can carry it down the pipeline.

When a branch resolves in execute, the pipeline sends back the index it carried and the real outcome. Only then is the table entry updated and the outcome shifted into the history. Nothing changes when a prediction is made. Each entry holds a direction bit and a flag that records whether the previous prediction from that entry was wrong. The direction flips only after two mispredictions in a row.

Top module: `branch_dir_predictor`

## Requirements
- R1: After reset every entry predicts not taken with its last-prediction-wrong flag clear, and the history is all zeros, so `pred_taken` is 0 for every fetch PC.
- R2: `pred_index` is {history, fetch_pc[PC_IDX_W+1:2]}: the history occupies the upper HIST_W bits and PC bits 1:0 and those above PC_IDX_W+1 have no effect.
- R3: `pred_taken` is the direction bit (1 = taken) of the entry at `pred_index`, valid in the same cycle as `fetch_pc`.
- R4: An update whose outcome matches the entry's direction leaves the direction unchanged and clears the wrong flag.
- R5: An update whose outcome differs from the direction while the wrong flag is clear leaves the direction unchanged and sets the flag.
- R6: An update whose outcome differs from the direction while the wrong flag is set flips the direction and clears the flag.
- R7: Each update shifts `upd_taken` into history bit 0 (1 = taken), moving older outcomes toward the top and dropping the oldest.
- R8: An update writes only the entry at `upd_index`, whatever the current history; all other entries keep their state.
- R9: With `upd_valid` low, neither the table nor the history changes, so the prediction for a held fetch PC is steady.
- R10: A correct outcome between two mispredictions resets the count, so wrong-right-wrong does not flip the direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | PC being fetched |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_index | output | PC_IDX_W+HIST_W | Table index used for this prediction |
| upd_valid | input | 1 | A resolved branch update is present |
| upd_index | input | PC_IDX_W+HIST_W | Index carried from prediction time |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The table walk mixes updates and idle cycles over PCs whose discarded low and high bits are set. This shows whether the index really drops those bits and folds in the history. Repeated outcomes on one index separate the two-mistake rule from a plain one-mistake flip. Wrong-right-wrong sequences show that a correct outcome resets the mistake count. Updates made while the history points at a different set show that the carried index, not the current history, chooses the entry written.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef struct packed {
        logic dir;   // 1 = predict taken
        logic miss;  // 1 = previous prediction from this entry was wrong
    } bp_entry_t;

    localparam bp_entry_t BP_ENTRY_RESET = '{dir: 1'b0, miss: 1'b0};

    function automatic bp_entry_t bp_entry_next(bp_entry_t cur, logic taken);
        bp_entry_t nxt;
        if (cur.dir == taken) begin
            nxt = '{dir: cur.dir, miss: 1'b0};
        end else if (!cur.miss) begin
            nxt = '{dir: cur.dir, miss: 1'b1};
        end else begin
            nxt = '{dir: ~cur.dir, miss: 1'b0};
        end
        return nxt;
    endfunction

endpackage

// File: rtl/bp_history.sv
module bp_history #(
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist_o
);
    typedef struct packed {
        logic [HIST_W-1:0] bits;
    } hist_state_t;

    hist_state_t state_d, state_q;

    generate
        if (HIST_W == 1) begin : g_single
            always_comb begin
                state_d = state_q;
                if (shift_en) state_d.bits = shift_bit;
            end
        end else begin : g_multi
            always_comb begin
                state_d = state_q;
                if (shift_en) state_d.bits = {state_q.bits[HIST_W-2:0], shift_bit};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign hist_o = state_q.bits;

    // R7
    hist_shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> hist_o[0] == $past(shift_bit));

    // R9
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist_o));

endmodule

// File: rtl/bp_index.sv
module bp_index #(
    parameter int PC_W     = 32,
    parameter int PC_IDX_W = 4,
    parameter int HIST_W   = 2,
    localparam int IDX_W   = PC_IDX_W + HIST_W
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);
    // Word-aligned fetch: bits 1:0 carry no information.
    localparam int PC_LSB = 2;

    always_comb begin
        idx = {hist, pc[PC_LSB +: PC_IDX_W]};
    end

endmodule

// File: rtl/bp_table.sv
module bp_table
    import bp_pkg::*;
#(
    parameter int IDX_W = 6,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_dir,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    typedef struct packed {
        bp_entry_t [DEPTH-1:0] ent;
    } table_state_t;

    table_state_t tab_d, tab_q;

    always_comb begin
        tab_d = tab_q;
        if (wr_en) tab_d.ent[wr_idx] = bp_entry_next(tab_q.ent[wr_idx], wr_taken);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tab_q <= {DEPTH{BP_ENTRY_RESET}};
        else        tab_q <= tab_d;
    end

    assign rd_dir = tab_q.ent[rd_idx].dir;

    // R5
    no_flip_after_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !tab_q.ent[wr_idx].miss)
        |=> tab_q.ent[$past(wr_idx)].dir == $past(tab_q.ent[wr_idx].dir));

    // R4
    right_clears_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tab_q.ent[wr_idx].dir == wr_taken)
        |=> !tab_q.ent[$past(wr_idx)].miss);

    // R6
    second_miss_flips_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tab_q.ent[wr_idx].miss && tab_q.ent[wr_idx].dir != wr_taken)
        |=> tab_q.ent[$past(wr_idx)].dir == wr_taken_q);

    logic wr_taken_q;
    always_ff @(posedge clk) wr_taken_q <= wr_taken;

    // R9
    table_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(tab_q));

endmodule

// File: rtl/branch_dir_predictor.sv
module branch_dir_predictor #(
    parameter int PC_W     = 32,
    parameter int PC_IDX_W = 4,
    parameter int HIST_W   = 2,
    localparam int IDX_W   = PC_IDX_W + HIST_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  fetch_pc,
    output logic             pred_taken,
    output logic [IDX_W-1:0] pred_index,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_index,
    input  logic             upd_taken
);
    logic [HIST_W-1:0] hist;
    logic [IDX_W-1:0]  idx;

    bp_history #(.HIST_W(HIST_W)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (upd_valid),
        .shift_bit (upd_taken),
        .hist_o    (hist)
    );

    bp_index #(.PC_W(PC_W), .PC_IDX_W(PC_IDX_W), .HIST_W(HIST_W)) u_index (
        .pc   (fetch_pc),
        .hist (hist),
        .idx  (idx)
    );

    bp_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (idx),
        .rd_dir   (pred_taken),
        .wr_en    (upd_valid),
        .wr_idx   (upd_index),
        .wr_taken (upd_taken)
    );

    assign pred_index = idx;

    // R9
    steady_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_valid ##1 $stable(fetch_pc)) |-> $stable(pred_taken));

    // R2
    index_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_valid ##1 $stable(fetch_pc)) |-> $stable(pred_index));

endmodule

// File: tb/tb_branch_dir_predictor.sv
`timescale 1ns/1ps
module tb_branch_dir_predictor;
    localparam int PC_W = 32;
    localparam int PC_IDX_W = 4;
    localparam int HIST_W = 2;
    localparam int IDX_W = PC_IDX_W + HIST_W;
    localparam int DEPTH = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PC_W-1:0] fetch_pc = '0;
    logic pred_taken;
    logic [IDX_W-1:0] pred_index;
    logic upd_valid = 1'b0;
    logic [IDX_W-1:0] upd_index = '0;
    logic upd_taken = 1'b0;

    always #2 clk = ~clk;

    branch_dir_predictor #(.PC_W(PC_W), .PC_IDX_W(PC_IDX_W), .HIST_W(HIST_W)) dut (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
        .pred_index(pred_index), .upd_valid(upd_valid), .upd_index(upd_index),
        .upd_taken(upd_taken)
    );

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // Bench model built from the requirements: {dir, wrong}
    logic [1:0] m_tab [DEPTH];
    logic [HIST_W-1:0] m_hist;

    function automatic logic [1:0] rule_next(logic [1:0] e, logic t);
        if (e[1] == t) return {e[1], 1'b0};       // R4
        else if (!e[0]) return {e[1], 1'b1};      // R5
        else return {~e[1], 1'b0};                // R6
    endfunction

    task automatic model_update(logic [IDX_W-1:0] i, logic t);
        m_tab[i] = rule_next(m_tab[i], t);
        m_hist = {m_hist[HIST_W-2:0], t};         // R7
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic             uv;
        logic [IDX_W-1:0] ui;
        logic             ut;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0010, 1'b1, 6'h04, 1'b1},
        '{32'h0000_0010, 1'b1, 6'h04, 1'b1},
        '{32'hFFFF_FF13, 1'b1, 6'h14, 1'b1},
        '{32'h0000_0050, 1'b0, 6'h00, 1'b0},
        '{32'h1234_5652, 1'b1, 6'h34, 1'b0},
        '{32'h0000_0010, 1'b1, 6'h04, 1'b0},
        '{32'h0000_0010, 1'b1, 6'h3C, 1'b1},
        '{32'h0000_003C, 1'b1, 6'h3C, 1'b1},
        '{32'h0000_003C, 1'b1, 6'h3F, 1'b1},
        '{32'h8000_003D, 1'b0, 6'h00, 1'b1},
        '{32'h0000_0004, 1'b1, 6'h01, 1'b0},
        '{32'h0000_0004, 1'b1, 6'h21, 1'b1},
        '{32'h0000_0004, 1'b1, 6'h21, 1'b1},
        '{32'hABCD_0087, 1'b1, 6'h31, 1'b1},
        '{32'h0000_0084, 1'b1, 6'h31, 1'b1},
        '{32'h0000_0084, 1'b1, 6'h21, 1'b0},
        '{32'h0000_0084, 1'b1, 6'h21, 1'b0},
        '{32'h0000_0084, 1'b0, 6'h21, 1'b0},
        '{32'h7777_7778, 1'b1, 6'h16, 1'b0},
        '{32'h7777_7778, 1'b1, 6'h0A, 1'b1}
    };

    function automatic logic [IDX_W-1:0] m_index(logic [PC_W-1:0] pc);
        return {m_hist, pc[PC_IDX_W+1:2]};
    endfunction

    task automatic probe(string req, logic [PC_W-1:0] pc, logic exp_dir);
        @(negedge clk);
        fetch_pc = pc;
        #1;
        check(req, pred_taken, exp_dir);
    endtask

    task automatic upd(logic [IDX_W-1:0] i, logic t);
        @(negedge clk);
        upd_valid = 1'b1; upd_index = i; upd_taken = t;
        @(posedge clk);
        model_update(i, t);
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) m_tab[i] = 2'b00;
        m_hist = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            fetch_pc = 32'h0000_1000 + 32'(i * 20) + 32'(i);
            #1;
            check("R1 pred", pred_taken, 1'b0);
            check("R1 hist", pred_index[IDX_W-1 -: HIST_W], 0);
        end

        // R2 R3: index layout, discarded PC bits
        @(negedge clk); fetch_pc = 32'hFFFF_FF2F; #1;
        check("R2 index", pred_index, 6'h0B);

        // Vector walk
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            fetch_pc = VECS[v].pc;
            upd_valid = VECS[v].uv; upd_index = VECS[v].ui; upd_taken = VECS[v].ut;
            #1;
            check("R2 vec index", pred_index, m_index(VECS[v].pc));
            check("R3 vec pred", pred_taken, m_tab[m_index(VECS[v].pc)][1]);
            @(posedge clk);
            if (VECS[v].uv) model_update(VECS[v].ui, VECS[v].ut);
        end
        @(negedge clk); upd_valid = 1'b0;

        // Directed: two-mistake rule on entry 0x03 (PC 0x0C in set 0)
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) m_tab[i] = 2'b00;
        m_hist = '0;
        upd(6'h03, 1'b1);
        upd(6'h3F, 1'b0); upd(6'h3F, 1'b0);
        probe("R5 single miss keeps not-taken", 32'h0000_000C, 1'b0);
        upd(6'h03, 1'b1);
        upd(6'h3F, 1'b0); upd(6'h3F, 1'b0);
        probe("R6 second miss flips to taken", 32'h0000_000C, 1'b1);
        // R8: set 0 entry 0x02 untouched by writes to 0x03 and 0x3F
        probe("R8 neighbour unchanged", 32'h0000_0008, 1'b0);

        // R10: wrong, right, wrong keeps taken
        upd(6'h03, 1'b0); upd(6'h03, 1'b1); upd(6'h03, 1'b0);
        upd(6'h3F, 1'b0); upd(6'h3F, 1'b0);
        probe("R10 no flip after reset of count", 32'h0000_000C, 1'b1);
        // R4: correct outcome keeps direction
        upd(6'h03, 1'b1);
        upd(6'h3F, 1'b0); upd(6'h3F, 1'b0);
        probe("R4 correct keeps taken", 32'h0000_000C, 1'b1);
        upd(6'h03, 1'b0);
        upd(6'h3F, 1'b0); upd(6'h3F, 1'b0);
        probe("R4 right cleared flag, one miss no flip", 32'h0000_000C, 1'b1);

        // R7: history bits after taken then not taken
        upd(6'h2A, 1'b1); upd(6'h2A, 1'b0);
        @(negedge clk); fetch_pc = 32'h0000_000C; #1;
        check("R7 history order", pred_index, 6'h23);

        // R8: write into set 1 while history selects set 2
        upd(6'h17, 1'b1); upd(6'h17, 1'b1);   // history now 2'b11
        upd(6'h2A, 1'b0); upd(6'h2A, 1'b1);   // history now 2'b01
        probe("R8 carried index written", 32'h0000_001C, 1'b1);

        // R9: idle cycles hold prediction
        @(negedge clk); fetch_pc = 32'h0000_001C;
        repeat (5) @(posedge clk);
        @(negedge clk); #1;
        check("R9 idle hold pred", pred_taken, 1'b1);
        check("R9 idle hold index", pred_index, 6'h17);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule